// File: doc/BRIEF.md
# Microcode Dispatch Unit

This block carries out the multiway branch step of a microcoded processor. A 32-bit source word is rotated left, and a field of up to 12 low bits is kept according to a length field. That field is ORed into a 12-bit base address, and the result selects one of 4096 sixteen-bit words in a dispatch table. The selected word supplies the next micro-PC. It can also push a return address onto a 16-entry micro-stack. The value pushed depends on two bits of the word and on an own-address option in the instruction.

The dispatch also has two side effects. It latches a 12-bit constant from the instruction into a readable register. It can optionally copy the source word into the virtual memory address (VMA) register. A host port fills the table and presets the PC. A single-step mode freezes the machine state except on step pulses.

A table word has this layout:
- bit 15 is the push request.
- bit 14 is the no-delay bit. When it is clear, the instruction after the dispatch runs first.
- bits 13:0 are the branch target.

A dispatch is accepted on one enabled clock edge. It takes effect on the next enabled edge, because the table is read synchronously.

Top module: `udisp_unit`

## Requirements
- R1: A dispatch accepted on an enabled edge (di_valid high, no dispatch pending) loads pc_o on the next enabled edge with the zero-extended bits 13:0 of the table word at the dispatch index. Table words are written through hw_en/hw_addr/hw_data. pc_set_en loads pc_o directly on the next edge.
- R2: The dispatch index equals di_base OR (low 12 bits of di_src rotated left by di_rot, masked to the low di_len bits). A di_len above 12 counts as 12. Rotating left by (32 - k) mod 32 therefore selects the bits starting at bit k, with wrap-around.
- R3: With di_len = 0 the index is di_base alone, whatever di_src holds.
- R4: With di_rot = 0, di_len = 8 and di_base = 0, the index is the low 8 bits of the source word. This mode reads the first 256 table locations from a Q-register value.
- R5: A table word with bit 15 clear pushes nothing. With bit 15 set, the value pushed is the PC at acceptance when bit 14 is set, and that PC plus one when bit 14 is clear.
- R6: di_own subtracts one from the pushed value. When di_own is combined with bit 14 clear, the two adjustments cancel. Every pushed value wraps modulo 2^16.
- R7: Every accepted dispatch latches di_const into const_o on its accepting edge.
- R8: An accepted dispatch with di_wvma high copies di_src into vma_o. With di_wvma low, vma_o is unchanged.
- R9: top_o shows the most recent live stack entry, and reads 0 when the stack is empty.
  - The stack holds 16 entries.
  - stk_pop removes the top entry; a pop on an empty stack is ignored.
  - A push on a full stack overwrites the oldest entry.
  - A push in the same cycle as a pop wins, and the pop is ignored.
- R10: While step_mode is high, pc_o (except through pc_set_en), the stack, const_o, vma_o and dispatch progress change only on cycles with step_pulse high.
- R11: After a synchronous reset, pc_o, top_o, const_o and vma_o are 0, and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_mode | input | 1 | Single-step mode enable |
| step_pulse | input | 1 | Allows one state update while step_mode is high |
| hw_en | input | 1 | Host table write strobe |
| hw_addr | input | 12 | Host table write address |
| hw_data | input | 16 | Host table write data |
| pc_set_en | input | 1 | Host micro-PC load strobe |
| pc_set_val | input | 16 | Host micro-PC load value |
| di_valid | input | 1 | Dispatch instruction present |
| di_src | input | 32 | Source word |
| di_rot | input | 5 | Left rotation amount |
| di_len | input | 4 | Field length in bits |
| di_base | input | 12 | Base address |
| di_const | input | 12 | Dispatch constant |
| di_own | input | 1 | Own-address option (pushed value minus one) |
| di_wvma | input | 1 | Copy the source word into the VMA register |
| stk_pop | input | 1 | Pop the micro-stack |
| pc_o | output | 16 | Micro-PC |
| top_o | output | 16 | Top of the micro-stack (0 when empty) |
| const_o | output | 12 | Dispatch constant register |
| vma_o | output | 32 | VMA register |

## Verification
Two situations are hard to reach from the ports.

The first is a push on a full stack, where the oldest entry must be lost. The bench sets up that case as follows:
- It makes 17 pushes, each from a dispatch at a freshly preset PC.
- It pops back down and checks that the fifteenth pop exposes the second value pushed.
- It checks that the sixteenth pop empties the stack.

The second is the wrapped push adjustments at PC 0 and PC 0xFFFF. The bench reaches them by presetting the PC to those values. It then dispatches on a base-only index whose table word it has rewritten with the chosen push and no-delay bits.

// File: rtl/udisp_pkg.sv
`timescale 1ns/1ps
package udisp_pkg;
  localparam int ENTRY_W = 16;
  localparam int TGT_W   = 14;

  typedef struct packed {
    logic             push;
    logic             nodelay;
    logic [TGT_W-1:0] target;
  } disp_entry_t;
endpackage

// File: rtl/udisp_index.sv
`timescale 1ns/1ps
module udisp_index #(
  parameter int DW = 32,
  parameter int AW = 12,
  localparam int RW = $clog2(DW),
  localparam int LW = $clog2(AW + 1)
) (
  input  logic [DW-1:0] src,
  input  logic [RW-1:0] rot,
  input  logic [LW-1:0] len,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] idx
);
  logic [2*DW-1:0] dbl_sh;
  logic [DW-1:0]   rot_w;
  logic [LW-1:0]   lenc;
  logic [AW:0]     one_sh;
  logic [AW-1:0]   mask;

  always_comb begin
    dbl_sh = {src, src} >> (DW - int'(rot));
    rot_w  = dbl_sh[DW-1:0];
    lenc   = (len > LW'(AW)) ? LW'(AW) : len;
    one_sh = (AW+1)'(1) << lenc;
    mask   = one_sh[AW-1:0] - AW'(1);
    idx    = base | (rot_w[AW-1:0] & mask);
  end

  // R3
  always_comb begin
    if (len == '0) begin
      zero_len_chk: assert (idx == base);
    end
  end
endmodule

// File: rtl/udisp_table.sv
`timescale 1ns/1ps
module udisp_table #(
  parameter int AW = 12,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/udisp_ustack.sv
`timescale 1ns/1ps
module udisp_ustack #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_val,
  input  logic         pop,
  output logic [W-1:0] top
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [CW-1:0] cnt;
  logic          do_pop;

  assign do_pop = pop && !push && (cnt != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (push) begin
      wr_ptr <= wr_ptr + PW'(1);
      if (cnt != CW'(DEPTH)) cnt <= cnt + CW'(1);
    end else if (do_pop) begin
      wr_ptr <= wr_ptr - PW'(1);
      cnt    <= cnt - CW'(1);
    end
  end

  assign top = (cnt == '0) ? '0 : mem[wr_ptr - PW'(1)];

  // R9
  push_depth_chk: assert property (@(posedge clk) disable iff (rst)
    (push && cnt < CW'(DEPTH)) |=> cnt == $past(cnt) + CW'(1));
  // R9
  full_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (push && cnt == CW'(DEPTH)) |=> cnt == CW'(DEPTH));
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt == '0) |=> (cnt == '0) && $stable(wr_ptr));
endmodule

// File: rtl/udisp_unit.sv
`timescale 1ns/1ps
module udisp_unit
  import udisp_pkg::*;
#(
  parameter int SRC_W     = 32,
  parameter int ADDR_W    = 12,
  parameter int PC_W      = 16,
  parameter int STK_DEPTH = 16,
  parameter int CONST_W   = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         step_mode,
  input  logic                         step_pulse,
  input  logic                         hw_en,
  input  logic [ADDR_W-1:0]            hw_addr,
  input  logic [ENTRY_W-1:0]           hw_data,
  input  logic                         pc_set_en,
  input  logic [PC_W-1:0]              pc_set_val,
  input  logic                         di_valid,
  input  logic [SRC_W-1:0]             di_src,
  input  logic [$clog2(SRC_W)-1:0]     di_rot,
  input  logic [$clog2(ADDR_W+1)-1:0]  di_len,
  input  logic [ADDR_W-1:0]            di_base,
  input  logic [CONST_W-1:0]           di_const,
  input  logic                         di_own,
  input  logic                         di_wvma,
  input  logic                         stk_pop,
  output logic [PC_W-1:0]              pc_o,
  output logic [PC_W-1:0]              top_o,
  output logic [CONST_W-1:0]           const_o,
  output logic [SRC_W-1:0]             vma_o
);
  logic                en;
  logic                issue;
  logic [ADDR_W-1:0]   idx;
  logic [ENTRY_W-1:0]  tbl_q;
  disp_entry_t         entry;
  logic                pend_q;
  logic                own_q;
  logic [PC_W-1:0]     snap_q;
  logic [PC_W-1:0]     pc_q;
  logic [CONST_W-1:0]  const_q;
  logic [SRC_W-1:0]    vma_q;
  logic                push;
  logic [PC_W-1:0]     push_val;
  logic                pop;

  assign en    = !step_mode || step_pulse;
  assign issue = en && di_valid && !pend_q;

  udisp_index #(.DW(SRC_W), .AW(ADDR_W)) u_index (
    .src  (di_src),
    .rot  (di_rot),
    .len  (di_len),
    .base (di_base),
    .idx  (idx)
  );

  udisp_table #(.AW(ADDR_W), .DW(ENTRY_W)) u_table (
    .clk   (clk),
    .we    (hw_en),
    .waddr (hw_addr),
    .wdata (hw_data),
    .re    (issue),
    .raddr (idx),
    .rdata (tbl_q)
  );

  assign entry = disp_entry_t'(tbl_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      own_q   <= 1'b0;
      snap_q  <= '0;
      const_q <= '0;
      vma_q   <= '0;
    end else if (issue) begin
      pend_q  <= 1'b1;
      own_q   <= di_own;
      snap_q  <= pc_q;
      const_q <= di_const;
      if (di_wvma) vma_q <= di_src;
    end else if (en && pend_q) begin
      pend_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                pc_q <= '0;
    else if (pc_set_en)     pc_q <= pc_set_val;
    else if (en && pend_q)  pc_q <= PC_W'(entry.target);
  end

  assign push     = en && pend_q && entry.push;
  assign push_val = snap_q + {{(PC_W-1){1'b0}}, ~entry.nodelay}
                           - {{(PC_W-1){1'b0}}, own_q};
  assign pop      = en && stk_pop;

  udisp_ustack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_val (push_val),
    .pop      (pop),
    .top      (top_o)
  );

  assign pc_o    = pc_q;
  assign const_o = const_q;
  assign vma_o   = vma_q;

  // R7
  const_latch_chk: assert property (@(posedge clk) disable iff (rst)
    issue |=> const_q == $past(di_const));
  // R10
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !pc_set_en) |=> $stable(pc_q) && $stable(const_q) && $stable(vma_q) && $stable(pend_q));
  // R1
  pend_once_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pend_q) |=> !pend_q);
  // R8
  vma_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !(issue && di_wvma) |=> $stable(vma_q));
endmodule

// File: tb/sim_udisp_unit.sv
`timescale 1ns/1ps
module sim_udisp_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_mode = 0, step_pulse = 0;
  logic        hw_en = 0;
  logic [11:0] hw_addr = 0;
  logic [15:0] hw_data = 0;
  logic        pc_set_en = 0;
  logic [15:0] pc_set_val = 0;
  logic        di_valid = 0;
  logic [31:0] di_src = 0;
  logic [4:0]  di_rot = 0;
  logic [3:0]  di_len = 0;
  logic [11:0] di_base = 0;
  logic [11:0] di_const = 0;
  logic        di_own = 0, di_wvma = 0, stk_pop = 0;
  logic [15:0] pc_o, top_o;
  logic [11:0] const_o;
  logic [31:0] vma_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  udisp_unit u0 (
    .clk(clk), .rst(rst), .step_mode(step_mode), .step_pulse(step_pulse),
    .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data),
    .pc_set_en(pc_set_en), .pc_set_val(pc_set_val),
    .di_valid(di_valid), .di_src(di_src), .di_rot(di_rot), .di_len(di_len),
    .di_base(di_base), .di_const(di_const), .di_own(di_own), .di_wvma(di_wvma),
    .stk_pop(stk_pop), .pc_o(pc_o), .top_o(top_o), .const_o(const_o), .vma_o(vma_o)
  );

  function automatic logic [13:0] tgt(input int a);
    return 14'(a * 5 + 3);
  endfunction

  function automatic logic [11:0] exp_idx(input logic [31:0] s, input int off,
                                          input int len, input logic [11:0] base);
    logic [31:0] r;
    int l;
    r = (s >> off) | (s << (32 - off));
    l = (len > 12) ? 12 : len;
    return base | (r[11:0] & 12'((1 << l) - 1));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [15:0] d);
    hw_en = 1; hw_addr = a; hw_data = d; tick(); hw_en = 0;
  endtask

  task automatic setpc(input logic [15:0] v);
    pc_set_en = 1; pc_set_val = v; tick(); pc_set_en = 0;
  endtask

  task automatic dispatch(input logic [31:0] s, input int off, input int len,
                          input logic [11:0] base, input logic [11:0] cst,
                          input logic own, input logic wvma);
    di_src = s; di_rot = 5'((32 - off) & 31); di_len = 4'(len); di_base = base;
    di_const = cst; di_own = own; di_wvma = wvma; di_valid = 1;
    tick();
    di_valid = 0; di_own = 0; di_wvma = 0;
    tick();
  endtask

  task automatic pop1();
    stk_pop = 1; tick(); stk_pop = 0;
  endtask

  task automatic t_reset();
    chk("R11 pc", 32'(pc_o), 0);
    chk("R11 top", 32'(top_o), 0);
    chk("R11 const", 32'(const_o), 0);
    chk("R11 vma", vma_o, 0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < 4096; a++) hwrite(12'(a), {2'b01, tgt(a)});
  endtask

  task automatic t_table();
    int bases[3] = '{0, 4095, 12'h5A3};
    foreach (bases[i]) begin
      dispatch(32'h0, 0, 0, 12'(bases[i]), 12'h0, 0, 0);
      chk("R1 pc from table", 32'(pc_o), 32'(tgt(bases[i])));
    end
  endtask

  task automatic t_field();
    logic [31:0] srcs[5] = '{32'hDEADBEEF, 32'h0F0F1234, 32'hF000000A, 32'h89ABCDEF, 32'hFFFFFFFF};
    int offs[5] = '{4, 0, 28, 13, 7};
    int lens[5] = '{5, 12, 8, 15, 3};
    logic [11:0] bss[5] = '{12'h300, 12'h000, 12'h800, 12'h000, 12'hC00};
    for (int i = 0; i < 5; i++) begin
      dispatch(srcs[i], offs[i], lens[i], bss[i], 12'h0, 0, 0);
      chk("R2 field index", 32'(pc_o), 32'(tgt(int'(exp_idx(srcs[i], offs[i], lens[i], bss[i])))));
    end
  endtask

  task automatic t_zero();
    dispatch(32'hFFFFFFFF, 9, 0, 12'h2C1, 12'h0, 0, 0);
    chk("R3 zero length", 32'(pc_o), 32'(tgt(12'h2C1)));
  endtask

  task automatic t_q();
    dispatch(32'h123456C7, 0, 8, 12'h000, 12'h0, 0, 0);
    chk("R4 q mode", 32'(pc_o), 32'(tgt(12'hC7)));
  endtask

  task automatic t_const();
    dispatch(32'h0, 0, 0, 12'h001, 12'hABC, 0, 0);
    chk("R7 const a", 32'(const_o), 32'hABC);
    dispatch(32'h0, 0, 0, 12'h002, 12'h123, 0, 0);
    chk("R7 const b", 32'(const_o), 32'h123);
  endtask

  task automatic t_vma();
    dispatch(32'hCAFEF00D, 0, 0, 12'h003, 12'h0, 0, 1);
    chk("R8 vma load", vma_o, 32'hCAFEF00D);
    dispatch(32'h11112222, 0, 0, 12'h003, 12'h0, 0, 0);
    chk("R8 vma kept", vma_o, 32'hCAFEF00D);
  endtask

  task automatic push_case(input string tag, input logic p, input logic n, input logic own,
                           input logic [15:0] pc, input logic [15:0] exp_top);
    hwrite(12'h001, {p, n, 14'h0123});
    setpc(pc);
    dispatch(32'h0, 0, 0, 12'h001, 12'h0, own, 0);
    chk({tag, " top"}, 32'(top_o), 32'(exp_top));
    chk({tag, " pc"}, 32'(pc_o), 32'h0123);
  endtask

  task automatic t_push();
    push_case("R5 push plain", 1, 1, 0, 16'h0100, 16'h0100);
    push_case("R5 push delay", 1, 0, 0, 16'h0200, 16'h0201);
    push_case("R6 own", 1, 1, 1, 16'h0300, 16'h02FF);
    push_case("R6 own delay cancel", 1, 0, 1, 16'h0400, 16'h0400);
    push_case("R6 wrap down", 1, 1, 1, 16'h0000, 16'hFFFF);
    push_case("R6 wrap up", 1, 0, 0, 16'hFFFF, 16'h0000);
    push_case("R5 no push", 0, 1, 0, 16'h0500, 16'h0000);
  endtask

  task automatic t_stack();
    do_reset();
    hwrite(12'h001, {2'b11, 14'h0123});
    for (int k = 0; k < 17; k++) begin
      setpc(16'(100 + k));
      dispatch(32'h0, 0, 0, 12'h001, 12'h0, 0, 0);
    end
    chk("R9 top after overflow", 32'(top_o), 116);
    for (int k = 0; k < 15; k++) pop1();
    chk("R9 oldest overwritten", 32'(top_o), 101);
    pop1();
    chk("R9 empty after 16 pops", 32'(top_o), 0);
    pop1();
    chk("R9 pop on empty", 32'(top_o), 0);
    setpc(16'h0777);
    dispatch(32'h0, 0, 0, 12'h001, 12'h0, 0, 0);
    chk("R9 push after empty pop", 32'(top_o), 32'h0777);
    pop1();
    chk("R9 single entry popped", 32'(top_o), 0);
  endtask

  task automatic t_step();
    logic [11:0] c0;
    hwrite(12'h001, {2'b01, tgt(1)});
    c0 = const_o;
    step_mode = 1;
    setpc(16'h0200);
    di_src = 0; di_rot = 0; di_len = 0; di_base = 12'h010; di_const = 12'h777;
    di_own = 0; di_wvma = 1; di_valid = 1;
    tick(); tick(); tick();
    chk("R10 const held", 32'(const_o), 32'(c0));
    chk("R10 pc held", 32'(pc_o), 32'h0200);
    step_pulse = 1; tick(); step_pulse = 0; di_valid = 0; di_wvma = 0;
    chk("R10 const on pulse", 32'(const_o), 32'h777);
    tick(); tick();
    chk("R10 pc waits for pulse", 32'(pc_o), 32'h0200);
    step_pulse = 1; tick(); step_pulse = 0;
    chk("R10 pc on second pulse", 32'(pc_o), 32'(tgt(12'h010)));
    step_mode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_reset();
    t_fill();
    t_table();
    t_field();
    t_zero();
    t_q();
    t_const();
    t_vma();
    t_push();
    t_stack();
    t_step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule